// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block is the digital side of a four-channel DAC's serial port. It takes a three-wire serial stream (bit clock, data, active-low frame select), collects 24-bit frames and runs the command each frame carries. For every channel it keeps two 16-bit stages: an input register and a DAC register. The DAC register drives that channel's output code.

All serial and load pins are oversampled by a faster system clock. The block has no analogue behaviour; it produces only the four codes a converter would turn into voltages.

A separate active-low load pin controls when input registers move into DAC registers. A falling edge on it copies every channel at once. Holding it low makes plain input writes pass straight through to the outputs.

The reset code is selected by a strap pin: zero or midscale.

Top module: `qdac_serial_dec`

## Requirements
- R1: A frame is the serial bits taken on falling edges of `sclk` while `sync_n` is low, MSB first. Bits 23:20 are the command, bits 19:16 the channel mask and bits 15:0 the data code. The frame runs when `sync_n` rises.
- R2: Mask bit 0 selects channel A, bit 1 B, bit 2 C and bit 3 D. Any combination of bits may be set in one frame, and every selected channel is acted on.
- R3: Command 0001 loads the data into the input register of each selected channel. While `ldac_n` is high, no DAC register changes.
- R4: While `ldac_n` is low, command 0001 also loads the data into the DAC register of each selected channel.
- R5: Command 0010 copies each selected channel's input register into its DAC register.
- R6: Command 0011 loads the data into both the input register and the DAC register of each selected channel.
- R7: A falling edge on `ldac_n` copies all four input registers into their DAC registers.
- R8: The following commands change no input register and no DAC register:
  - 0000 (no operation)
  - 0100, 0101, 0111, 1000 and 1001
  - the reserved codes 1010 through 1111
- R9: The reset code is 0x0000 when `rstsel` is low and 0x8000 when it is high. All input and DAC registers take this code while `rst_n` is low, and also after a frame with command 0110.
- R10: A frame that held any bit count other than 24 is discarded without any state change.
- R11: An output changes on the third `clk` rising edge after `sync_n` rises or `ldac_n` falls at the pins, and not earlier. `sclk` may run at up to a quarter of the `clk` rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| sclk | input | 1 | Serial bit clock; idles high |
| sdin | input | 1 | Serial data, taken on `sclk` falling edges |
| sync_n | input | 1 | Active-low frame select |
| ldac_n | input | 1 | Active-low load of DAC registers |
| rstsel | input | 1 | Reset code select: 0 gives zero scale, 1 gives midscale |
| dac_a | output | 16 | DAC register code, channel A |
| dac_b | output | 16 | DAC register code, channel B |
| dac_c | output | 16 | DAC register code, channel C |
| dac_d | output | 16 | DAC register code, channel D |

## Verification
Every pin passes through two synchroniser flops and one edge-detect flop. The register effects of a frame therefore land on the third `clk` rising edge after `sync_n` rises. An `ldac_n` fall takes effect on the same edge.

The bench drives inputs on falling `clk` edges. After each transaction it waits five cycles before it compares the outputs with its own model. One directed frame also samples the outputs after the first, second and third rising edges. This shows the old codes hold for two cycles and the new code appears on the third. `ldac_n` changes are kept well apart from frame ends, so the order of the two never depends on a shared edge.

// File: rtl/qdac_serial_dec.sv
module qdac_serial_dec #(
  parameter int DATA_W      = 16,
  parameter int CMD_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              sync_n,
  input  logic              ldac_n,
  input  logic              rstsel,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic [DATA_W-1:0] dac_c,
  output logic [DATA_W-1:0] dac_d
);
  localparam int NCH     = 4;
  localparam int FRAME_W = CMD_W + NCH + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  localparam logic [CMD_W-1:0] OP_WRIN  = CMD_W'(1);
  localparam logic [CMD_W-1:0] OP_UPD   = CMD_W'(2);
  localparam logic [CMD_W-1:0] OP_WRUPD = CMD_W'(3);
  localparam logic [CMD_W-1:0] OP_SWRST = CMD_W'(6);

  logic [SYNC_STAGES-1:0] sclk_s, sdin_s, sync_s, ldac_s;
  logic                   sclk_d, sync_d, ldac_d;
  logic                   sclk_l, sdin_l, sync_l, ldac_l;
  logic                   sclk_fall, sync_fall, sync_rise, ldac_fall, shift_en;
  logic [FRAME_W-1:0]     shreg;
  logic [CNT_W-1:0]       bit_cnt, cnt_base;
  logic                   frame_go;
  logic [CMD_W-1:0]       op;
  logic [NCH-1:0]         chmask;
  logic [DATA_W-1:0]      code, rst_code;
  logic [NCH-1:0][DATA_W-1:0] in_q, in_nxt, dac_q;
  logic [NCH-1:0]         dac_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s <= '1;
      sdin_s <= '0;
      sync_s <= '1;
      ldac_s <= '1;
      sclk_d <= 1'b1;
      sync_d <= 1'b1;
      ldac_d <= 1'b1;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-2:0], sclk};
      sdin_s <= {sdin_s[SYNC_STAGES-2:0], sdin};
      sync_s <= {sync_s[SYNC_STAGES-2:0], sync_n};
      ldac_s <= {ldac_s[SYNC_STAGES-2:0], ldac_n};
      sclk_d <= sclk_l;
      sync_d <= sync_l;
      ldac_d <= ldac_l;
    end
  end

  assign sclk_l    = sclk_s[SYNC_STAGES-1];
  assign sdin_l    = sdin_s[SYNC_STAGES-1];
  assign sync_l    = sync_s[SYNC_STAGES-1];
  assign ldac_l    = ldac_s[SYNC_STAGES-1];
  assign sclk_fall = sclk_d & ~sclk_l;
  assign sync_fall = sync_d & ~sync_l;
  assign sync_rise = ~sync_d & sync_l;
  assign ldac_fall = ldac_d & ~ldac_l;
  assign shift_en  = sclk_fall & ~sync_l;
  assign cnt_base  = sync_fall ? '0 : bit_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      if (shift_en) shreg <= {shreg[FRAME_W-2:0], sdin_l};
      if (shift_en && cnt_base != CNT_SAT) bit_cnt <= cnt_base + 1'b1;
      else                                  bit_cnt <= cnt_base;
    end
  end

  assign frame_go = sync_rise && (bit_cnt == CNT_FULL);
  assign op       = shreg[FRAME_W-1 -: CMD_W];
  assign chmask   = shreg[DATA_W +: NCH];
  assign code     = shreg[DATA_W-1:0];
  assign rst_code = rstsel ? {1'b1, {(DATA_W-1){1'b0}}} : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign in_nxt[g] = (frame_go && chmask[g] && (op == OP_WRIN || op == OP_WRUPD))
                       ? code : in_q[g];
    assign dac_hit[g] = frame_go && chmask[g] &&
                        (op == OP_UPD || op == OP_WRUPD || (op == OP_WRIN && !ldac_l));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= {NCH{rst_code}};
      dac_q <= {NCH{rst_code}};
    end else if (frame_go && op == OP_SWRST) begin
      in_q  <= {NCH{rst_code}};
      dac_q <= {NCH{rst_code}};
    end else begin
      in_q <= in_nxt;
      for (int i = 0; i < NCH; i++)
        if (ldac_fall || dac_hit[i]) dac_q[i] <= in_nxt[i];
    end
  end

  assign dac_a = dac_q[0];
  assign dac_b = dac_q[1];
  assign dac_c = dac_q[2];
  assign dac_d = dac_q[3];
endmodule

// File: rtl/qdac_serial_dec_chk.sv
module qdac_serial_dec_chk #(
  parameter int DATA_W  = 16,
  parameter int CMD_W   = 4,
  parameter int FRAME_W = 24,
  parameter int CNT_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rstsel,
  input logic                     go,
  input logic                     sync_rise,
  input logic                     ldac_fall,
  input logic                     ldac_lvl,
  input logic [CNT_W-1:0]         cnt,
  input logic [CMD_W-1:0]         op,
  input logic [3:0]               mask,
  input logic [DATA_W-1:0]        data,
  input logic [3:0][DATA_W-1:0]   inr,
  input logic [3:0][DATA_W-1:0]   dac
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  logic ign_op;
  assign ign_op = (op == 4'd0) || (op == 4'd4) || (op == 4'd5) || (op == 4'd7) ||
                  (op == 4'd8) || (op == 4'd9) || (op >= 4'd10);

  AST_WRIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 4'd1 && ldac_lvl && !ldac_fall) |=> $stable(dac)); // R3

  AST_IGNORED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ign_op && !ldac_fall) |=> ($stable(dac) && $stable(inr))); // R8

  AST_BAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && cnt != CNT_W'(FRAME_W) && !ldac_fall) |=> ($stable(dac) && $stable(inr))); // R10

  AST_LDAC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && !go) |=> (dac == inr)); // R7

  for (genvar g = 0; g < 4; g++) begin : g_chk
    AST_WRUPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == 4'd3 && mask[g]) |=> (dac[g] == $past(data) && inr[g] == $past(data))); // R6

    AST_WRIN_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == 4'd1 && !ldac_lvl && mask[g]) |=> (dac[g] == $past(data))); // R4

    AST_SWRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == 4'd6) |=> (dac[g] == ($past(rstsel) ? MID : '0))); // R9
  end
endmodule

bind qdac_serial_dec qdac_serial_dec_chk #(
  .DATA_W(DATA_W), .CMD_W(CMD_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rstsel(rstsel), .go(frame_go), .sync_rise(sync_rise),
  .ldac_fall(ldac_fall), .ldac_lvl(ldac_l), .cnt(bit_cnt), .op(op), .mask(chmask),
  .data(code), .inr(in_q), .dac(dac_q)
);

// File: tb/qdac_serial_dec_bench.sv
module qdac_serial_dec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdin = 1'b0, sync_n = 1'b1, ldac_n = 1'b1, rstsel = 1'b0;
  logic [15:0] dac_a, dac_b, dac_c, dac_d;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_in  [4];
  logic [15:0] exp_dac [4];

  always #2.5 clk = ~clk;

  qdac_serial_dec u_qdac_serial_dec (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .sync_n(sync_n),
    .ldac_n(ldac_n), .rstsel(rstsel),
    .dac_a(dac_a), .dac_b(dac_b), .dac_c(dac_c), .dac_d(dac_d)
  );

  function automatic logic [15:0] out_of(int ch);
    case (ch)
      0: return dac_a;
      1: return dac_b;
      2: return dac_c;
      default: return dac_d;
    endcase
  endfunction

  function automatic logic [15:0] reset_code();
    return rstsel ? 16'h8000 : 16'h0000;
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd1: return ldac_n ? "R3" : "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd6: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check_one(string req, int ch, logic [15:0] want);
    n_cmp++;
    if (out_of(ch) !== want) begin
      n_bad++;
      $display("FAIL %s ch%0d: got %h expected %h", req, ch, out_of(ch), want);
    end
  endtask

  task automatic check_all(string req);
    for (int ch = 0; ch < 4; ch++) check_one(req, ch, exp_dac[ch]);
  endtask

  task automatic model_frame(logic [23:0] w);
    logic [3:0] op = w[23:20];
    logic [3:0] m  = w[19:16];
    logic [15:0] d = w[15:0];
    for (int ch = 0; ch < 4; ch++) begin
      case (op)
        4'd1: if (m[ch]) begin exp_in[ch] = d; if (!ldac_n) exp_dac[ch] = d; end
        4'd2: if (m[ch]) exp_dac[ch] = exp_in[ch];
        4'd3: if (m[ch]) begin exp_in[ch] = d; exp_dac[ch] = d; end
        4'd6: begin exp_in[ch] = reset_code(); exp_dac[ch] = reset_code(); end
        default: ;
      endcase
    end
  endtask

  task automatic send(int nbits, logic [23:0] w, bit timed);
    logic [15:0] old [4];
    @(negedge clk); sync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 24) ? w[23-i] : 1'b0;
      repeat (2) @(negedge clk); sclk = 1'b0;
      repeat (2) @(negedge clk); sclk = 1'b1;
    end
    repeat (2) @(negedge clk);
    for (int ch = 0; ch < 4; ch++) old[ch] = exp_dac[ch];
    sync_n = 1'b1;
    if (nbits == 24) model_frame(w);
    if (timed) begin
      @(negedge clk);
      for (int ch = 0; ch < 4; ch++) check_one("R11 early1", ch, old[ch]);
      @(negedge clk);
      for (int ch = 0; ch < 4; ch++) check_one("R11 early2", ch, old[ch]);
      @(negedge clk);
      check_all("R11 due");
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic set_ldac(logic v);
    @(negedge clk);
    if (ldac_n && !v) for (int ch = 0; ch < 4; ch++) exp_dac[ch] = exp_in[ch];
    ldac_n = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset(logic sel);
    @(negedge clk); rstsel = sel; rst_n = 1'b0;
    for (int ch = 0; ch < 4; ch++) begin exp_in[ch] = reset_code(); exp_dac[ch] = reset_code(); end
    repeat (4) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    do_reset(1'b0);
    check_all("R9 reset zero");

    send(24, 24'h1_1_8000, 0); check_all("R1/R3 write input A");
    send(24, 24'h2_1_0000, 0); check_all("R1/R5 update A");
    send(24, 24'h3_3_FFFF, 0); check_all("R2/R6 A and B");
    send(24, 24'h3_C_1234, 0); check_all("R2/R6 C and D");
    send(24, 24'h3_1_4321, 1);

    send(23, 24'h3_F_AAAA, 0); check_all("R10 short frame");
    send(25, 24'h3_F_AAAA, 0); check_all("R10 long frame");
    send(8,  24'h3_F_AAAA, 0); check_all("R10 byte frame");
    send(24, 24'h2_F_0000, 0); check_all("R10 inputs untouched");

    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 2 || op == 3 || op == 6) continue;
      send(24, {4'(op), 4'hF, 16'h5555}, 0);
      check_all("R8 ignored op");
    end
    send(24, 24'h2_F_0000, 0); check_all("R8 inputs untouched");

    send(24, 24'h1_F_0F0F, 0); check_all("R3 ldac high holds");
    set_ldac(1'b0);            check_all("R7 ldac fall copies");
    send(24, 24'h1_2_7777, 0); check_all("R4 ldac low passes");
    set_ldac(1'b1);

    @(negedge clk); rstsel = 1'b1;
    send(24, 24'h6_0_1111, 0); check_all("R9 soft reset mid");
    send(24, 24'h3_F_2222, 0);
    do_reset(1'b1);            check_all("R9 reset mid");

    for (int it = 0; it < 250; it++) begin
      int r = $urandom % 10;
      if (r < 6) begin
        logic [23:0] w = {4'($urandom), 4'($urandom), 16'($urandom)};
        if (w[23:20] == 4'd6) rstsel = 1'($urandom);
        send(24, w, 0);
        check_all({req_of(w[23:20]), " random"});
      end else if (r == 6) begin
        int nb = ($urandom % 2) ? 23 : 25;
        send(nb, 24'($urandom), 0);
        check_all("R10 random length");
      end else if (r < 9) begin
        set_ldac(~ldac_n);
        check_all("R7 random ldac");
      end else begin
        send(24, {4'd2, 4'($urandom), 16'h0}, 0);
        check_all("R5 random update");
      end
    end
    summary();
  end
endmodule